// File: doc/BRIEF.md
# Flash Block Modification Guard

This block sits beside the command logic of a 16-bit-word flash array split into equal blocks. Each cycle it may be handed one request: an erase or word write aimed at a word address, or a change to the lock state. From the block's lock bit, a one-way permanent lock, the level on the reset pin and a program-supply-valid flag, it decides whether the operation may go ahead. The answer is a one-cycle grant or reject pulse in the next cycle.

Every rejection leaves a pair of sticky error bits in an 8-bit status byte. The byte is laid out the way the host polls it. Lock changes that are granted are applied inside the block, to the per-block lock bits, to the permanent bit, or to all lock bits at once. The per-block and permanent lock states are also presented as 16-bit identifier codes, which a read path can return as they stand.

The reset pin is given as a level code. Low puts the status byte back to its idle value and blocks every request. A high-voltage level lets locked blocks be modified, but only until the permanent lock is set. After that, locked blocks are frozen for good.

Top module: `flash_lock_guard`

## Requirements
- R1: The block index is the top four bits, 18:15, of the 19-bit word address. Address bits 14:0 have no effect on any decision.
- R2: An erase (op 1) or write (op 2) to an unlocked block is granted when the supply is valid and the reset level is not low. grant_o pulses in the cycle after the request, reject_o stays 0, and no status bit changes. grant_o and reject_o are never 1 together.
- R3: An erase or write to a locked block at normal reset level (code 01) is rejected. It sets status bit 1, plus bit 5 for an erase or bit 4 for a write.
- R4: An erase or write to a locked block is granted when the reset level is high-voltage (code 1x) and the permanent lock is clear.
- R5: While the permanent lock is set, an erase or write to a locked block is rejected at every reset level, with the error bits of R3. Once set, the permanent lock never clears except through rst_ni.
- R6: An erase or write with vpp_ok_i=0 is rejected with status bit 3, plus bit 5 or bit 4. The supply check takes priority over the lock checks. Lock ops (3, 4, 5) with vpp_ok_i=0 are rejected with bits 3, 4 and 5.
- R7: Set-block-lock (op 3) sets the lock bit of the addressed block. While the permanent lock is set it is refused, with status bits 1, 4 and 5.
- R8: Set-permanent-lock (op 4) is granted only at the high-voltage reset level. At any other level it is refused with status bits 1, 4 and 5.
- R9: Clear-locks (op 5) clears all sixteen lock bits in one cycle. While the permanent lock is set it is refused, with bits 1, 4 and 5, and the lock bits are left as they were.
- R10: Status bits 5, 4, 3 and 1 stay set until a cycle with clr_status_i=1 clears them. Error bits raised in that same cycle remain set.
- R11: With the reset level low (code 00), the status byte becomes 80h on the next clock, no request is granted or rejected, and the lock bits are kept.
- R12: Status bit 7 always reads 1, and bits 6, 2 and 0 always read 0. id_blk_code_o is the lock bit of block id_blk_i in bit 0 with zeros above it. id_perm_code_o carries the permanent lock the same way. Both codes are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset; clears all locks, status 80h |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | 1 erase, 2 write, 3 set block lock, 4 set permanent lock, 5 clear all locks; others ignored |
| req_addr_i | input | 19 | Word address; bits 18:15 select the block |
| rp_lvl_i | input | 2 | Reset pin level: 00 low, 01 normal, 1x high-voltage |
| vpp_ok_i | input | 1 | Program supply above lockout |
| clr_status_i | input | 1 | Clear sticky status bits |
| id_blk_i | input | 4 | Block whose lock code is shown |
| grant_o | output | 1 | Request accepted (one cycle after request) |
| reject_o | output | 1 | Request refused (one cycle after request) |
| status_o | output | 8 | Status byte |
| blk_lock_o | output | 16 | Per-block lock bits |
| id_blk_code_o | output | 16 | Lock code of block id_blk_i |
| id_perm_code_o | output | 16 | Permanent lock code |

## Verification
Erase and write are swept over every block, over both non-low reset levels and over both supply states, with odd blocks locked. This separates the supply-first priority, the lock-at-normal rejection and the high-voltage override. The low address bits change with each request, which shows that only the top four bits pick the block. The same sweep is run again after the permanent lock is set, to show that the override no longer works. Lock-changing operations are tried with the supply invalid, at each reset level and before and after the permanent lock, which separates their three refusal causes. Dedicated sequences drive stickiness, clear-with-concurrent-error and a low reset level during a request.

// File: rtl/flg_pkg.sv
package flg_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_ERASE    = 3'd1,
    OP_WRITE    = 3'd2,
    OP_SET_BLK  = 3'd3,
    OP_SET_PERM = 3'd4,
    OP_CLR_BLKS = 3'd5
  } op_e;

  localparam logic [1:0] RP_LOW = 2'b00;

  localparam int SR_READY   = 7;
  localparam int SR_ERASE   = 5;
  localparam int SR_WRITE   = 4;
  localparam int SR_SUPPLY  = 3;
  localparam int SR_LOCKED  = 1;

  localparam logic [7:0] SR_IDLE   = 8'h80;
  localparam logic [7:0] SR_STICKY = 8'b0011_1010;
endpackage

// File: rtl/flg_decide.sv
module flg_decide
  import flg_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] op_i,
  input  logic       blk_locked_i,
  input  logic       perm_i,
  input  logic       hv_i,
  input  logic       vpp_ok_i,
  output logic       grant_o,
  output logic       reject_o,
  output logic [7:0] err_o,
  output logic       set_blk_o,
  output logic       set_perm_o,
  output logic       clr_blks_o
);
  logic is_erase, is_write, is_lock_op, known, deny;

  always_comb begin
    is_erase   = (op_i == OP_ERASE);
    is_write   = (op_i == OP_WRITE);
    is_lock_op = (op_i == OP_SET_BLK) || (op_i == OP_SET_PERM) || (op_i == OP_CLR_BLKS);
    known      = valid_i && (is_erase || is_write || is_lock_op);

    unique case (op_i)
      OP_ERASE, OP_WRITE: deny = blk_locked_i && (!hv_i || perm_i);
      OP_SET_BLK:         deny = perm_i;
      OP_SET_PERM:        deny = !hv_i;
      OP_CLR_BLKS:        deny = perm_i;
      default:            deny = 1'b0;
    endcase

    grant_o    = known && vpp_ok_i && !deny;
    reject_o   = known && !(vpp_ok_i && !deny);
    set_blk_o  = grant_o && (op_i == OP_SET_BLK);
    set_perm_o = grant_o && (op_i == OP_SET_PERM);
    clr_blks_o = grant_o && (op_i == OP_CLR_BLKS);

    err_o = '0;
    if (reject_o) begin
      // supply fault is reported in preference to a lock fault
      err_o[SR_SUPPLY] = !vpp_ok_i;
      err_o[SR_LOCKED] = vpp_ok_i;
      err_o[SR_ERASE]  = is_erase || is_lock_op;
      err_o[SR_WRITE]  = is_write || is_lock_op;
    end
  end
endmodule

// File: rtl/flg_lock_store.sv
module flg_lock_store #(
  parameter int NUM_BLK   = 16,
  parameter int BLK_IDX_W = $clog2(NUM_BLK)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BLK_IDX_W-1:0] blk_idx_i,
  input  logic                 set_blk_i,
  input  logic                 set_perm_i,
  input  logic                 clr_blks_i,
  output logic [NUM_BLK-1:0]   lock_o,
  output logic                 perm_o
);
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    logic lock_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      lock_q <= 1'b0;
      else if (clr_blks_i)                              lock_q <= 1'b0;
      else if (set_blk_i && blk_idx_i == BLK_IDX_W'(b)) lock_q <= 1'b1;
    end
    assign lock_o[b] = lock_q;
  end

  // one-way bit: only power-on reset returns it to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         perm_o <= 1'b0;
    else if (set_perm_i) perm_o <= 1'b1;
  end
endmodule

// File: rtl/flg_status.sv
module flg_status
  import flg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rp_low_i,
  input  logic       clr_i,
  input  logic [7:0] err_i,
  output logic [7:0] status_o
);
  logic [7:0] sticky_q, sticky_d;

  always_comb begin
    if (rp_low_i) sticky_d = '0;
    else          sticky_d = ((clr_i ? '0 : sticky_q) | err_i) & SR_STICKY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= sticky_d;
  end

  assign status_o = SR_IDLE | sticky_q;
endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
  import flg_pkg::*;
#(
  parameter int NUM_BLK    = 16,
  parameter int BLK_ADDR_W = 15,
  parameter int DATA_W     = 16,
  localparam int BLK_IDX_W = $clog2(NUM_BLK),
  localparam int ADDR_W    = BLK_IDX_W + BLK_ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [2:0]           req_op_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           rp_lvl_i,
  input  logic                 vpp_ok_i,
  input  logic                 clr_status_i,
  input  logic [BLK_IDX_W-1:0] id_blk_i,
  output logic                 grant_o,
  output logic                 reject_o,
  output logic [7:0]           status_o,
  output logic [NUM_BLK-1:0]   blk_lock_o,
  output logic [DATA_W-1:0]    id_blk_code_o,
  output logic [DATA_W-1:0]    id_perm_code_o
);
  logic [BLK_IDX_W-1:0] blk_idx;
  logic rp_low, hv, perm;
  logic dec_grant, dec_reject, set_blk, set_perm, clr_blks;
  logic [7:0] err;

  assign blk_idx = req_addr_i[ADDR_W-1 -: BLK_IDX_W];
  assign rp_low  = (rp_lvl_i == RP_LOW);
  assign hv      = rp_lvl_i[1];

  flg_decide u_decide (
    .valid_i      (req_valid_i && !rp_low),
    .op_i         (req_op_i),
    .blk_locked_i (blk_lock_o[blk_idx]),
    .perm_i       (perm),
    .hv_i         (hv),
    .vpp_ok_i     (vpp_ok_i),
    .grant_o      (dec_grant),
    .reject_o     (dec_reject),
    .err_o        (err),
    .set_blk_o    (set_blk),
    .set_perm_o   (set_perm),
    .clr_blks_o   (clr_blks)
  );

  flg_lock_store #(.NUM_BLK(NUM_BLK)) u_locks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .blk_idx_i  (blk_idx),
    .set_blk_i  (set_blk),
    .set_perm_i (set_perm),
    .clr_blks_i (clr_blks),
    .lock_o     (blk_lock_o),
    .perm_o     (perm)
  );

  flg_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rp_low_i (rp_low),
    .clr_i    (clr_status_i),
    .err_i    (err),
    .status_o (status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o  <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      grant_o  <= dec_grant;
      reject_o <= dec_reject;
    end
  end

  assign id_blk_code_o  = {{(DATA_W-1){1'b0}}, blk_lock_o[id_blk_i]};
  assign id_perm_code_o = {{(DATA_W-1){1'b0}}, perm};
endmodule

// File: rtl/flg_checker.sv
module flg_checker #(
  parameter int NUM_BLK   = 16,
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 16,
  parameter int BLK_IDX_W = $clog2(NUM_BLK)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [2:0]           req_op_i,
  input logic [ADDR_W-1:0]    req_addr_i,
  input logic [1:0]           rp_lvl_i,
  input logic                 vpp_ok_i,
  input logic                 clr_status_i,
  input logic                 grant_o,
  input logic                 reject_o,
  input logic [7:0]           status_o,
  input logic [NUM_BLK-1:0]   blk_lock_o,
  input logic [DATA_W-1:0]    id_perm_code_o
);
  logic       tgt_locked, rp_up, mod_op, any_op;
  logic [7:0] sticky;
  assign tgt_locked = blk_lock_o[req_addr_i[ADDR_W-1 -: BLK_IDX_W]];
  assign rp_up      = (rp_lvl_i != 2'b00);
  assign mod_op     = (req_op_i == 3'd1) || (req_op_i == 3'd2);
  assign any_op     = (req_op_i >= 3'd1) && (req_op_i <= 3'd5);
  assign sticky     = status_o & 8'b0011_1010;

  AST_GRANT_REJECT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o)); // R2
  AST_FIXED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] && !status_o[6] && !status_o[2] && !status_o[0]); // R12
  AST_LOW_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_up |=> status_o == 8'h80); // R11
  AST_LOW_NO_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_up |=> !grant_o && !reject_o); // R11
  AST_LOW_KEEPS_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rp_up |=> $stable(blk_lock_o)); // R11
  AST_PERM_ONE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_perm_code_o[0] |=> id_perm_code_o[0]); // R5
  AST_PERM_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rp_up && mod_op && tgt_locked && id_perm_code_o[0]) |=> reject_o); // R5
  AST_SUPPLY_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rp_up && any_op && !vpp_ok_i) |=> reject_o && status_o[3]); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rp_up && !clr_status_i) |=> (sticky & $past(sticky)) == $past(sticky)); // R10
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rp_up && req_op_i == 3'd5 && vpp_ok_i && !id_perm_code_o[0])
      |=> blk_lock_o == '0); // R9
endmodule

bind flash_lock_guard flg_checker #(
  .NUM_BLK(NUM_BLK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_op_i       (req_op_i),
  .req_addr_i     (req_addr_i),
  .rp_lvl_i       (rp_lvl_i),
  .vpp_ok_i       (vpp_ok_i),
  .clr_status_i   (clr_status_i),
  .grant_o        (grant_o),
  .reject_o       (reject_o),
  .status_o       (status_o),
  .blk_lock_o     (blk_lock_o),
  .id_perm_code_o (id_perm_code_o)
);

// File: tb/flash_lock_guard_tb.sv
module flash_lock_guard_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  req_op_i = '0;
  logic [18:0] req_addr_i = '0;
  logic [1:0]  rp_lvl_i = 2'b01;
  logic        vpp_ok_i = 1'b1;
  logic        clr_status_i = 1'b0;
  logic [3:0]  id_blk_i = '0;
  logic        grant_o, reject_o;
  logic [7:0]  status_o;
  logic [15:0] blk_lock_o, id_blk_code_o, id_perm_code_o;

  int total = 0;
  int bad = 0;
  logic [15:0] m_lock = '0;
  logic        m_perm = 1'b0;
  logic [7:0]  m_sr = 8'h80;

  always #10 clk = ~clk;

  flash_lock_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
    .req_addr_i(req_addr_i), .rp_lvl_i(rp_lvl_i), .vpp_ok_i(vpp_ok_i),
    .clr_status_i(clr_status_i), .id_blk_i(id_blk_i), .grant_o(grant_o),
    .reject_o(reject_o), .status_o(status_o), .blk_lock_o(blk_lock_o),
    .id_blk_code_o(id_blk_code_o), .id_perm_code_o(id_perm_code_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // op: 0 none 1 erase 2 write 3 set blk 4 set perm 5 clr blks
  task automatic req(input logic [2:0] op, input int blk, input logic [1:0] rp,
                     input logic vpp, input logic clr, input string tag);
    logic e_g, e_r, deny, locked;
    logic [7:0] err;
    @(negedge clk);
    req_valid_i  = (op != 3'd0);
    req_op_i     = op;
    req_addr_i   = {blk[3:0], 15'((blk * 4099 + int'(op) * 37 + total * 11) & 32'h7fff)};
    rp_lvl_i     = rp;
    vpp_ok_i     = vpp;
    clr_status_i = clr;
    e_g = 1'b0; e_r = 1'b0; err = '0;
    locked = m_lock[blk];
    if (rp == 2'b00) begin
      m_sr = 8'h80;
    end else begin
      if (clr) m_sr = m_sr & ~8'h3A;
      if (op >= 3'd1 && op <= 3'd5) begin
        case (op)
          3'd1, 3'd2: deny = locked && (!rp[1] || m_perm);
          3'd3:       deny = m_perm;
          3'd4:       deny = !rp[1];
          default:    deny = m_perm;
        endcase
        if (vpp && !deny) begin
          e_g = 1'b1;
          if (op == 3'd3) m_lock[blk] = 1'b1;
          if (op == 3'd4) m_perm = 1'b1;
          if (op == 3'd5) m_lock = '0;
        end else begin
          e_r = 1'b1;
          err[3] = !vpp;
          err[1] = vpp;
          err[5] = (op != 3'd2);
          err[4] = (op != 3'd1);
        end
      end
      m_sr = m_sr | err;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0; req_op_i = '0; rp_lvl_i = 2'b01; vpp_ok_i = 1'b1; clr_status_i = 1'b0;
    chk({tag, " grant"}, 32'(grant_o), 32'(e_g));
    chk({tag, " reject"}, 32'(reject_o), 32'(e_r));
    chk({tag, " status"}, 32'(status_o), 32'(m_sr));
    chk({tag, " locks"}, 32'(blk_lock_o), 32'(m_lock));
    chk({tag, " perm"}, 32'(id_perm_code_o), 32'(m_perm));
  endtask

  task automatic sweep_mod(input string tag);
    for (int op = 1; op <= 2; op++)
      for (int rp = 1; rp <= 3; rp++)
        for (int v = 0; v <= 1; v++)
          for (int b = 0; b < 16; b++) begin
            string t;
            if (v == 0)                         t = "R6";
            else if (!m_lock[b])                t = "R2 R1";
            else if (m_perm)                    t = "R5";
            else if (rp >= 2)                   t = "R4";
            else                                t = "R3";
            req(3'(op), b, 2'(rp), v[0], 1'b1, {tag, " ", t});
          end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset status", 32'(status_o), 32'h80);
    chk("R12 reset locks", 32'(blk_lock_o), 32'h0);
    chk("R12 reset perm", 32'(id_perm_code_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 idle grant", 32'(grant_o), 32'h0);

    // R7 R1: lock odd blocks
    for (int b = 1; b < 16; b += 2) req(3'd3, b, 2'b01, 1'b1, 1'b0, "R7 set blk");
    for (int b = 0; b < 16; b++) begin
      id_blk_i = 4'(b);
      #1;
      chk("R12 id code", 32'(id_blk_code_o), 32'(m_lock[b]));
    end

    sweep_mod("pre-perm");

    // R10 stickiness and clearing
    req(3'd1, 3, 2'b01, 1'b1, 1'b1, "R10 err erase");
    repeat (3) @(negedge clk);
    chk("R10 hold", 32'(status_o), 32'(m_sr));
    req(3'd2, 5, 2'b01, 1'b1, 1'b0, "R10 accumulate");
    chk("R10 both bits", 32'(status_o), 32'hB2);
    req(3'd0, 0, 2'b01, 1'b1, 1'b1, "R10 clear");
    chk("R10 cleared", 32'(status_o), 32'h80);

    // R11 low reset level
    req(3'd1, 1, 2'b01, 1'b0, 1'b0, "R11 pre err");
    req(3'd1, 0, 2'b00, 1'b1, 1'b0, "R11 low");
    req(3'd3, 2, 2'b00, 1'b1, 1'b0, "R11 low lockop");

    // R6 R7 lock ops without supply
    req(3'd3, 4, 2'b01, 1'b0, 1'b1, "R6 R7 supply");
    req(3'd5, 0, 2'b10, 1'b0, 1'b1, "R6 R9 supply");

    // R9 clear all locks
    req(3'd5, 0, 2'b01, 1'b1, 1'b1, "R9 clear all");
    for (int b = 0; b < 16; b += 3) req(3'd3, b, 2'b01, 1'b1, 1'b0, "R7 relock");

    // R8 permanent lock needs high voltage
    req(3'd4, 0, 2'b01, 1'b1, 1'b1, "R8 normal");
    req(3'd4, 0, 2'b11, 1'b1, 1'b1, "R8 hv");

    // R7 R9 refused under permanent lock
    req(3'd3, 1, 2'b10, 1'b1, 1'b1, "R7 perm");
    req(3'd5, 0, 2'b10, 1'b1, 1'b1, "R9 perm");

    sweep_mod("post-perm");

    // R5 permanent lock survives a low reset level
    req(3'd0, 0, 2'b00, 1'b1, 1'b0, "R5 low");
    req(3'd1, 0, 2'b10, 1'b1, 1'b1, "R5 after low");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule